// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Data Cache Lookup

This block is the read lookup path of a set-associative first-level data cache. A load presents the low, untranslated bits of its virtual address. Those bits are the same in the virtual and the physical address, so the cache reads the tags and valid bits of the selected set straight away, while address translation is still running. The physical page number arrives later on its own strobe and serves directly as the tag. The block holds the set read result until that strobe comes, then compares.

On a hit the addressed 64-bit word of the line is returned. On a miss the block raises a one-cycle request to the next memory level carrying the physical line address. It then waits for the whole line to come back on the refill port. The line is written into the way chosen by a per-set round-robin pointer, and the requested word is delivered from the refill data. Only one request is in flight at a time, and `req_ready` shows when a new one can be taken.

The default geometry is a 48-bit physical address, 64 sets, 8 ways and 64-byte lines. The line offset (6 bits) and set index (6 bits) together fill the 12-bit page offset, and the remaining 36 bits form the tag, which equals the physical page number.

Top module: `vipt_l1_lookup`

## Requirements
- R1: After reset every line is invalid, every round-robin pointer is 0, `req_ready` is 1, and `resp_valid` and `miss_valid` are 0. The first lookup to any set therefore misses.
- R2: A request is taken at a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle `req_ready` is 0 until the cycle in which `resp_valid` is 1, where it is 1 again.
- R3: The set index is `req_off[11:6]` and the word select is `req_off[5:3]`; `req_off[2:0]` has no effect. After a request is taken, the tag compare happens at the first edge where `ppn_valid` is 1, however many cycles later. Until then there is no response and no miss.
- R4: When a valid way of the set holds a tag equal to `ppn`, the cycle after the compare edge has `resp_valid`=1, `resp_hit`=1, and `resp_data` equal to bits [64*w+63:64*w] of that line, where w is the word select.
- R5: When no valid way matches, the cycle after the compare edge has `miss_valid`=1 for exactly one cycle, with `miss_addr` = {ppn, set index} (42 bits). `resp_valid` is 0 in that cycle.
- R6: After a miss, the edge where `fill_valid` is 1 writes `fill_data` as the new line with tag `ppn`. The next cycle has `resp_valid`=1, `resp_hit`=0, and `resp_data` equal to the requested word of `fill_data`.
- R7: Each set has a 3-bit round-robin pointer. A refill writes the way the pointer names, marks it valid, and increments the pointer modulo 8. The ninth distinct tag refilled into a set replaces the first one, and the other seven still hit.
- R8: A `ppn_valid` strobe while no request is waiting for it, and a `fill_valid` strobe while no miss is waiting for it, produce no response or miss and leave the stored lines unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_off | input | 12 | Page-offset bits of the load's virtual address |
| req_ready | output | 1 | Block can take a request this cycle |
| ppn_valid | input | 1 | Translated page number is present |
| ppn | input | 36 | Physical page number from translation |
| fill_valid | input | 1 | Refill line present from the next level |
| fill_data | input | 512 | Refill line, byte 0 in bits [7:0] |
| resp_valid | output | 1 | Load result valid, one cycle |
| resp_hit | output | 1 | 1 if the result came from a hit, 0 if from a refill |
| resp_data | output | 64 | Addressed 64-bit word |
| miss_valid | output | 1 | Miss request to the next level, one cycle |
| miss_addr | output | 42 | Physical line address of the miss |

## Verification
A corrupted valid bit or tag shows up at the very next lookup to that set. A hit turns into a one-cycle `miss_valid`, or a miss into a hit, one cycle after the page-number strobe. A wrong round-robin pointer stays invisible until a set has received nine refills. It then shows as a hit on the line that should have been evicted, or a miss on one that should have stayed, so the bench runs sets through many refills using a small pool of page numbers. A stale held set read only shows when the page number comes late, which is why translation delays are varied.

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup #(
  parameter int PA_W   = 48,
  parameter int PAGE_W = 12,
  parameter int SETS   = 64,
  parameter int WAYS   = 8,
  parameter int LINE_B = 64,
  parameter int WORD_W = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [PAGE_W-1:0]             req_off,
  output logic                          req_ready,
  input  logic                          ppn_valid,
  input  logic [PA_W-PAGE_W-1:0]        ppn,
  input  logic                          fill_valid,
  input  logic [LINE_B*8-1:0]           fill_data,
  output logic                          resp_valid,
  output logic                          resp_hit,
  output logic [WORD_W-1:0]             resp_data,
  output logic                          miss_valid,
  output logic [PA_W-$clog2(LINE_B)-1:0] miss_addr
);
  localparam int OFF_W  = $clog2(LINE_B);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = PA_W - PAGE_W;
  localparam int LINE_W = LINE_B * 8;
  localparam int BSEL_W = $clog2(WORD_W / 8);
  localparam int WSEL_W = OFF_W - BSEL_W;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int ENT    = SETS * WAYS;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_FILL} state_t;
  state_t state_q;

  logic [TAG_W-1:0]  tag_mem  [ENT];
  logic [LINE_W-1:0] data_mem [ENT];
  logic [ENT-1:0]    valid_q;
  logic [WAY_W-1:0]  rr_q [SETS];

  logic [IDX_W-1:0]  idx_q;
  logic [WSEL_W-1:0] wsel_q;
  logic [TAG_W-1:0]  ppn_q;
  logic [TAG_W-1:0]  set_tag_q [WAYS];
  logic [WAYS-1:0]   set_vld_q;

  logic [WAYS-1:0]   hit_vec;
  logic [WAY_W-1:0]  hit_way;
  logic              hit_any;
  logic [WAY_W-1:0]  victim;
  logic              accept, compare, refill;
  logic              unused_bsel;

  assign unused_bsel = ^req_off[BSEL_W-1:0];
  assign req_ready = (state_q == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign compare   = (state_q == S_LOOK) && ppn_valid;
  assign refill    = (state_q == S_FILL) && fill_valid;
  assign victim    = rr_q[idx_q];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = set_vld_q[w] && (set_tag_q[w] == ppn);
  end

  assign hit_any = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  always_ff @(posedge clk) begin
    if (accept)
      for (int w = 0; w < WAYS; w++)
        set_tag_q[w] <= tag_mem[{req_off[PAGE_W-1:OFF_W], WAY_W'(w)}];
    if (refill) begin
      tag_mem[{idx_q, victim}]  <= ppn_q;
      data_mem[{idx_q, victim}] <= fill_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      valid_q    <= '0;
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
      idx_q      <= '0;
      wsel_q     <= '0;
      ppn_q      <= '0;
      set_vld_q  <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_data  <= '0;
      miss_valid <= 1'b0;
      miss_addr  <= '0;
    end else begin
      resp_valid <= 1'b0;
      miss_valid <= 1'b0;
      case (state_q)
        S_IDLE: if (accept) begin
          idx_q   <= req_off[PAGE_W-1:OFF_W];
          wsel_q  <= req_off[OFF_W-1:BSEL_W];
          for (int w = 0; w < WAYS; w++)
            set_vld_q[w] <= valid_q[{req_off[PAGE_W-1:OFF_W], WAY_W'(w)}];
          state_q <= S_LOOK;
        end
        S_LOOK: if (compare) begin
          ppn_q <= ppn;
          if (hit_any) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b1;
            resp_data  <= data_mem[{idx_q, hit_way}][wsel_q*WORD_W +: WORD_W];
            state_q    <= S_IDLE;
          end else begin
            miss_valid <= 1'b1;
            miss_addr  <= {ppn, idx_q};
            state_q    <= S_FILL;
          end
        end
        S_FILL: if (refill) begin
          valid_q[{idx_q, victim}] <= 1'b1;
          rr_q[idx_q] <= victim + 1'b1;
          resp_valid  <= 1'b1;
          resp_hit    <= 1'b0;
          resp_data   <= fill_data[wsel_q*WORD_W +: WORD_W];
          state_q     <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vipt_l1_lookup_chk.sv
module vipt_l1_lookup_chk #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [IDX_W-1:0] req_idx,
  input logic             ppn_valid,
  input logic [TAG_W-1:0] ppn,
  input logic             fill_valid,
  input logic             resp_valid,
  input logic             resp_hit,
  input logic             miss_valid,
  input logic [TAG_W+IDX_W-1:0] miss_addr
);
  logic             look_q;
  logic [IDX_W-1:0] idx_seen;
  logic [TAG_W-1:0] ppn_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      look_q   <= 1'b0;
      idx_seen <= '0;
      ppn_seen <= '0;
    end else begin
      if (req_valid && req_ready) begin
        look_q   <= 1'b1;
        idx_seen <= req_idx;
      end else if (look_q && ppn_valid) begin
        look_q   <= 1'b0;
        ppn_seen <= ppn;
      end
    end
  end

  assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_ready_on_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> req_ready);
  assert_wait_ppn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (look_q && !ppn_valid) |=> (!resp_valid && !miss_valid));
  assert_miss_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> (miss_addr == {ppn_seen, idx_seen}));
  assert_miss_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resp_valid, miss_valid}));
  assert_miss_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |=> !miss_valid);
  assert_refill_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> $past(fill_valid));
endmodule

bind vipt_l1_lookup vipt_l1_lookup_chk #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_idx(req_off[PAGE_W-1:OFF_W]), .ppn_valid(ppn_valid), .ppn(ppn),
  .fill_valid(fill_valid), .resp_valid(resp_valid), .resp_hit(resp_hit),
  .miss_valid(miss_valid), .miss_addr(miss_addr)
);

// File: tb/sim_vipt_l1_lookup.sv
`timescale 1ns/1ps
module sim_vipt_l1_lookup;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         req_valid = 0;
  logic [11:0]  req_off = '0;
  logic         req_ready;
  logic         ppn_valid = 0;
  logic [35:0]  ppn = '0;
  logic         fill_valid = 0;
  logic [511:0] fill_data = '0;
  logic         resp_valid, resp_hit, miss_valid;
  logic [63:0]  resp_data;
  logic [41:0]  miss_addr;

  vipt_l1_lookup u0 (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  logic [35:0]  m_tag  [64][8];
  bit           m_vld  [64][8];
  logic [511:0] m_data [64][8];
  int           m_rr   [64];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] rand_line();
    logic [511:0] l;
    for (int i = 0; i < 16; i++) l[i*32 +: 32] = $urandom;
    return l;
  endfunction

  function automatic int find_way(input int s, input logic [35:0] t);
    for (int w = 0; w < 8; w++) if (m_vld[s][w] && m_tag[s][w] == t) return w;
    return -1;
  endfunction

  task automatic access(input int s, input int ws, input logic [35:0] p, input int dly, input int fdly);
    int w;
    logic [511:0] line;
    chk(req_ready == 1, "R2", 64'(req_ready), 64'd1);
    req_valid = 1;
    req_off = {6'(s), 3'(ws), 3'($urandom)};
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R2", 64'(req_ready), 64'd0);
    for (int d = 0; d < dly; d++) begin
      @(negedge clk);
      chk(!resp_valid && !miss_valid, "R3", {62'd0, resp_valid, miss_valid}, 64'd0);
    end
    ppn_valid = 1; ppn = p;
    @(negedge clk);
    ppn_valid = 0; ppn = $urandom;
    w = find_way(s, p);
    if (w >= 0) begin
      chk(resp_valid && resp_hit && !miss_valid, "R4", {61'd0, resp_valid, resp_hit, miss_valid}, 64'd6);
      chk(resp_data == m_data[s][w][ws*64 +: 64], "R4", resp_data, m_data[s][w][ws*64 +: 64]);
    end else begin
      chk(miss_valid && !resp_valid, "R5", {62'd0, miss_valid, resp_valid}, 64'd2);
      chk(miss_addr == {p, 6'(s)}, "R5", 64'(miss_addr), 64'({p, 6'(s)}));
      for (int d = 0; d < fdly; d++) begin
        @(negedge clk);
        chk(!miss_valid && !resp_valid, "R5", {62'd0, miss_valid, resp_valid}, 64'd0);
      end
      line = rand_line();
      fill_valid = 1; fill_data = line;
      @(negedge clk);
      fill_valid = 0;
      chk(resp_valid && !resp_hit, "R6", {62'd0, resp_valid, resp_hit}, 64'd2);
      chk(resp_data == line[ws*64 +: 64], "R6", resp_data, line[ws*64 +: 64]);
      m_tag[s][m_rr[s]] = p; m_vld[s][m_rr[s]] = 1; m_data[s][m_rr[s]] = line;
      m_rr[s] = (m_rr[s] + 1) % 8;
    end
    chk(req_ready == 1, "R2", 64'(req_ready), 64'd1);
  endtask

  initial begin
    logic [35:0] pool [12];
    void'($urandom(32'd20240611));
    for (int s = 0; s < 64; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < 8; w++) m_vld[s][w] = 0;
    end
    for (int i = 0; i < 12; i++) pool[i] = {4'(i), 32'($urandom)};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !resp_valid && !miss_valid, "R1", {61'd0, req_ready, resp_valid, miss_valid}, 64'd4);

    // R1: cold miss, then R4 hit on same line, other word
    access(3, 0, pool[0], 0, 0);
    access(3, 7, pool[0], 0, 0);
    // R3: late ppn, byte bits ignored, word select
    access(3, 2, pool[0], 6, 0);
    access(10, 5, pool[1], 4, 3);
    // R8: stray strobes while idle
    ppn_valid = 1; ppn = pool[0];
    @(negedge clk); ppn_valid = 0;
    chk(!resp_valid && !miss_valid, "R8", {62'd0, resp_valid, miss_valid}, 64'd0);
    fill_valid = 1; fill_data = rand_line();
    @(negedge clk); fill_valid = 0;
    chk(!resp_valid && !miss_valid, "R8", {62'd0, resp_valid, miss_valid}, 64'd0);
    access(3, 4, pool[0], 1, 0);
    // R7: nine distinct tags into set 40
    for (int i = 0; i < 9; i++) access(40, i % 8, pool[i], 1, 1);
    chk(find_way(40, pool[0]) < 0, "R7", 64'(find_way(40, pool[0])), -64'd1);
    access(40, 1, pool[1], 0, 0);
    access(40, 0, pool[0], 0, 0);
    access(40, 3, pool[8], 0, 0);
    // random mix
    for (int n = 0; n < 400; n++)
      access(int'($urandom % 4) * 17, int'($urandom % 8), pool[$urandom % 12],
             int'($urandom % 4), int'($urandom % 3));
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule